// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block sits between a 6502-style CPU bus, a picture-processor pattern bus and the cartridge memories. The CPU programs it with writes into a sixteen-byte register page at $40C0-$40CF. From those registers it builds extended program-ROM and character-memory addresses, selects work RAM, and drives the nametable select line. It can also raise a scanline-counting interrupt. Scanline detection happens outside the block: a one-cycle `scan_tick` pulse per line comes in as an input.

Program space is cut into four 8 KiB slots. The lower three are switchable; the top slot always holds the last bank. Pattern space is cut into eight 1 KiB windows, each with its own bank register. A build parameter replaces banked character ROM with one flat 8 KiB character RAM. All registers are sampled on the rising edge of the system clock `clk`. `rst` is a synchronous, active-high reset.

Top module: `bank_mapper`

## Requirements
- R1: A register latches only on a clock edge where `cpu_m2`=1, `cpu_rw`=0 and `cpu_addr` is exactly one of $40C0-$40CE. Writes with M2 low, reads, writes to $40CF and writes outside the page change nothing.
- R2: Reset sets every bank register to 0, mirroring to vertical (mode 3), and the interrupt to disabled with no request pending and the line count at 0. `irq_n` is 1.
- R3: In the ROM build, `chr_addr` = {bank register $40C0+w, `ppu_addr[9:0]`}, where the window w = `ppu_addr[12:10]`.
- R4: For CPU addresses $8000-$DFFF, `prg_addr` = {bank, `cpu_addr[12:0]`}. The bank comes from $40C8 for slot 0 ($8000), $40C9 for slot 1 and $40CA for slot 2. The slot is `cpu_addr[14:13]`.
- R5: For CPU addresses $E000-$FFFF, the bank field of `prg_addr` is all ones, whatever the bank registers hold.
- R6: $40CB bits [1:0] select mirroring. 0 drives `ciram_a10` to 0, 1 drives it to 1, 2 copies `ppu_addr[11]` (horizontal) and 3 copies `ppu_addr[10]` (vertical).
- R7: `prg_rom_ce_n` is low exactly on reads with `cpu_addr[15]`=1. `wram_ce_n` is low exactly for $6000-$7FFF. `xram_ce_n` is low exactly for $5000-$5FFF. The ROM select and a RAM select are never low together.
- R8: In the RAM build, `chr_addr` = `ppu_addr[12:0]` with the upper bits 0, and $40C0-$40C7 have no effect. `chr_we_n` is low on a pattern write below $2000. In the ROM build `chr_we_n` stays 1.
- R9: Each `scan_tick` adds one to an 8-bit line count. A write to $40CE loads the target and clears the count. A tick in the same cycle as that write is dropped.
- R10: If the interrupt is enabled and a tick brings the count equal to the target, `irq_n` goes low at that edge. It stays low until acknowledged. While disabled, no request is raised.
- R11: A write to $40CC clears the request and disables the interrupt. It wins over a match in the same cycle. A write to $40CD enables the interrupt and leaves the count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU bus phase, high while data is valid |
| ppu_addr | input | 14 | Picture-processor address |
| ppu_rd_n | input | 1 | Pattern read strobe, active low |
| ppu_wr_n | input | 1 | Pattern write strobe, active low |
| scan_tick | input | 1 | One-cycle pulse per scanline |
| prg_addr | output | PRG_BANK_W+13 | Extended program-ROM address |
| prg_rom_ce_n | output | 1 | Program-ROM select, active low |
| wram_ce_n | output | 1 | 8 KiB save/work RAM select, active low |
| xram_ce_n | output | 1 | 2 KiB extra work RAM select, active low |
| chr_addr | output | CHR_BANK_W+10 | Extended character-memory address |
| chr_ce_n | output | 1 | Character-memory select, active low |
| chr_we_n | output | 1 | Character-RAM write enable, active low |
| ciram_a10 | output | 1 | Nametable select line |
| irq_n | output | 1 | Scanline interrupt, active low |

## Verification
Two events can land in the same cycle: a scanline tick that reaches the target, and a CPU write to the interrupt registers. The bench lines the two up on one clock edge. First the tick that would fire is paired with a disable write, and `irq_n` must stay high. Then the count is checked to have advanced, so that the match reappears only after a full 256-line wrap. Second, a target load is paired with a tick, and the request must come after exactly the target number of later ticks, which shows the paired tick was dropped.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int CHR_WINDOWS = 8;
    localparam int PRG_SLOTS   = 3;
    localparam int IRQ_CNT_W   = 8;

    localparam logic [11:0] REG_PAGE  = 12'h40C;
    localparam logic [3:0]  IDX_PRG0  = 4'h8;
    localparam logic [3:0]  IDX_MIRR  = 4'hB;
    localparam logic [3:0]  IDX_OFF   = 4'hC;
    localparam logic [3:0]  IDX_ON    = 4'hD;
    localparam logic [3:0]  IDX_TGT   = 4'hE;

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_HORZ   = 2'd2,
        MIR_VERT   = 2'd3
    } mirror_e;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        rw;
        logic        m2;
    } cpu_bus_t;

    function automatic logic page_write(input cpu_bus_t b);
        return b.m2 && !b.rw && (b.addr[15:4] == REG_PAGE);
    endfunction

    function automatic logic nt_select(input mirror_e m, input logic a10, input logic a11);
        case (m)
            MIR_ONE_LO: return 1'b0;
            MIR_ONE_HI: return 1'b1;
            MIR_HORZ:   return a11;
            default:    return a10;
        endcase
    endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
#(
    parameter int PRG_W = 5,
    parameter int CHR_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  cpu_bus_t                            bus,
    output logic [CHR_WINDOWS-1:0][CHR_W-1:0]   chr_bank,
    output logic [PRG_SLOTS-1:0][PRG_W-1:0]     prg_bank,
    output mirror_e                             mirror,
    output logic                                irq_off,
    output logic                                irq_on,
    output logic                                irq_load,
    output logic [IRQ_CNT_W-1:0]                irq_value
);

    logic       hit;
    logic [3:0] idx;

    assign hit = page_write(bus);
    assign idx = bus.addr[3:0];

    assign irq_off   = hit && (idx == IDX_OFF);
    assign irq_on    = hit && (idx == IDX_ON);
    assign irq_load  = hit && (idx == IDX_TGT);
    assign irq_value = bus.data[IRQ_CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            chr_bank <= '0;
            prg_bank <= '0;
            mirror   <= MIR_VERT;
        end else if (hit) begin
            for (int n = 0; n < CHR_WINDOWS; n++) begin
                if (idx == 4'(n)) chr_bank[n] <= bus.data[CHR_W-1:0];
            end
            for (int s = 0; s < PRG_SLOTS; s++) begin
                if (idx == IDX_PRG0 + 4'(s)) prg_bank[s] <= bus.data[PRG_W-1:0];
            end
            if (idx == IDX_MIRR) mirror <= mirror_e'(bus.data[1:0]);
        end
    end

    // R1: with no qualified page write, no bank or mirroring state moves
    a_r1_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !hit |=> ($stable(chr_bank) && $stable(prg_bank) && $stable(mirror)));

endmodule

// File: rtl/mapper_irq.sv
module mapper_irq
    import mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 off,
    input  logic                 on,
    input  logic                 load,
    input  logic [IRQ_CNT_W-1:0] value,
    output logic                 pending
);

    logic [IRQ_CNT_W-1:0] count;
    logic [IRQ_CNT_W-1:0] target;
    logic [IRQ_CNT_W-1:0] count_next;
    logic                 enabled;
    logic                 hit_now;

    assign count_next = count + 1'b1;
    assign hit_now    = tick && !load && enabled && (count_next == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            target  <= '0;
            enabled <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (load) begin
                target <= value;
                count  <= '0;
            end else if (tick) begin
                count <= count_next;
            end
            if (off) begin
                enabled <= 1'b0;
                pending <= 1'b0;
            end else begin
                if (on) enabled <= 1'b1;
                if (hit_now) pending <= 1'b1;
            end
        end
    end

    // R9: a target load leaves the line count at zero
    a_r9_load_clears_count: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == '0));

    // R10: a raised request holds until acknowledged
    a_r10_request_sticky: assert property (@(posedge clk) disable iff (rst)
        (pending && !off) |=> pending);

    // R10: a request can only appear on a tick
    a_r10_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (!pending && !tick) |=> !pending);

    // R11: acknowledge clears the request
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
        off |=> !pending);

endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
    import mapper_pkg::*;
#(
    parameter int PRG_W    = 5,
    parameter int CHR_W    = 8,
    parameter bit CHR_RAM  = 1'b0,
    parameter bit HAS_XRAM = 1'b1
) (
    input  logic [15:0]                        cpu_addr,
    input  logic                               cpu_rw,
    input  logic [13:0]                        ppu_addr,
    input  logic                               ppu_rd_n,
    input  logic                               ppu_wr_n,
    input  logic [CHR_WINDOWS-1:0][CHR_W-1:0]  chr_bank,
    input  logic [PRG_SLOTS-1:0][PRG_W-1:0]    prg_bank,
    input  mirror_e                            mirror,
    output logic [PRG_W+12:0]                  prg_addr,
    output logic                               prg_rom_ce_n,
    output logic                               wram_ce_n,
    output logic                               xram_ce_n,
    output logic [CHR_W+9:0]                   chr_addr,
    output logic                               chr_ce_n,
    output logic                               chr_we_n,
    output logic                               ciram_a10
);

    localparam logic [PRG_W-1:0] LAST_BANK = '1;

    logic [PRG_W-1:0] slot_bank;

    always_comb begin
        case (cpu_addr[14:13])
            2'd0:    slot_bank = prg_bank[0];
            2'd1:    slot_bank = prg_bank[1];
            2'd2:    slot_bank = prg_bank[2];
            default: slot_bank = LAST_BANK;
        endcase
    end

    assign prg_addr     = {slot_bank, cpu_addr[12:0]};
    assign prg_rom_ce_n = !(cpu_rw && cpu_addr[15]);
    assign wram_ce_n    = !(cpu_addr[15:13] == 3'b011);

    generate
        if (HAS_XRAM) begin : g_xram
            assign xram_ce_n = !(cpu_addr[15:12] == 4'h5);
        end else begin : g_no_xram
            assign xram_ce_n = 1'b1;
        end
    endgenerate

    assign chr_ce_n  = ppu_addr[13] || (ppu_rd_n && ppu_wr_n);
    assign ciram_a10 = nt_select(mirror, ppu_addr[10], ppu_addr[11]);

    generate
        if (CHR_RAM) begin : g_chr_ram
            logic unused_banks;
            assign unused_banks = ^chr_bank;
            assign chr_addr = {{(CHR_W-3){1'b0}}, ppu_addr[12:0]};
            assign chr_we_n = ppu_wr_n || ppu_addr[13];
        end else begin : g_chr_rom
            assign chr_addr = {chr_bank[ppu_addr[12:10]], ppu_addr[9:0]};
            assign chr_we_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 5,
    parameter int CHR_BANK_W = 8,
    parameter bit CHR_RAM    = 1'b0,
    parameter bit HAS_XRAM   = 1'b1,
    parameter bit HAS_IRQ    = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [15:0]             cpu_addr,
    input  logic [7:0]              cpu_data,
    input  logic                    cpu_rw,
    input  logic                    cpu_m2,
    input  logic [13:0]             ppu_addr,
    input  logic                    ppu_rd_n,
    input  logic                    ppu_wr_n,
    input  logic                    scan_tick,
    output logic [PRG_BANK_W+12:0]  prg_addr,
    output logic                    prg_rom_ce_n,
    output logic                    wram_ce_n,
    output logic                    xram_ce_n,
    output logic [CHR_BANK_W+9:0]   chr_addr,
    output logic                    chr_ce_n,
    output logic                    chr_we_n,
    output logic                    ciram_a10,
    output logic                    irq_n
);

    cpu_bus_t                                bus;
    logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0]  chr_bank;
    logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0]    prg_bank;
    mirror_e                                 mirror;
    logic                                    irq_off, irq_on, irq_load;
    logic [IRQ_CNT_W-1:0]                    irq_value;

    assign bus = '{addr: cpu_addr, data: cpu_data, rw: cpu_rw, m2: cpu_m2};

    mapper_regs #(.PRG_W(PRG_BANK_W), .CHR_W(CHR_BANK_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .chr_bank  (chr_bank),
        .prg_bank  (prg_bank),
        .mirror    (mirror),
        .irq_off   (irq_off),
        .irq_on    (irq_on),
        .irq_load  (irq_load),
        .irq_value (irq_value)
    );

    mapper_xlate #(
        .PRG_W(PRG_BANK_W), .CHR_W(CHR_BANK_W),
        .CHR_RAM(CHR_RAM), .HAS_XRAM(HAS_XRAM)
    ) u_xlate (
        .cpu_addr     (cpu_addr),
        .cpu_rw       (cpu_rw),
        .ppu_addr     (ppu_addr),
        .ppu_rd_n     (ppu_rd_n),
        .ppu_wr_n     (ppu_wr_n),
        .chr_bank     (chr_bank),
        .prg_bank     (prg_bank),
        .mirror       (mirror),
        .prg_addr     (prg_addr),
        .prg_rom_ce_n (prg_rom_ce_n),
        .wram_ce_n    (wram_ce_n),
        .xram_ce_n    (xram_ce_n),
        .chr_addr     (chr_addr),
        .chr_ce_n     (chr_ce_n),
        .chr_we_n     (chr_we_n),
        .ciram_a10    (ciram_a10)
    );

    generate
        if (HAS_IRQ) begin : g_irq
            logic pending;
            mapper_irq u_irq (
                .clk     (clk),
                .rst     (rst),
                .tick    (scan_tick),
                .off     (irq_off),
                .on      (irq_on),
                .load    (irq_load),
                .value   (irq_value),
                .pending (pending)
            );
            assign irq_n = !pending;
        end else begin : g_no_irq
            logic unused_irq;
            assign unused_irq = ^{scan_tick, irq_off, irq_on, irq_load, irq_value};
            assign irq_n = 1'b1;
        end
    endgenerate

    // R7: program ROM and a work RAM are never selected together
    a_r7_selects_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!prg_rom_ce_n && (!wram_ce_n || !xram_ce_n)));

    // R5: the top program slot always lands in the last bank
    a_r5_top_slot_fixed: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> (prg_addr[PRG_BANK_W+12:13] == '1));

    generate
        if (CHR_RAM) begin : g_chk_ram
            // R8: flat character RAM ignores the bank registers
            a_r8_flat_chr_addr: assert property (@(posedge clk) disable iff (rst)
                chr_addr == {{(CHR_BANK_W-3){1'b0}}, ppu_addr[12:0]});
        end else begin : g_chk_rom
            // R8: character ROM is never written
            a_r8_rom_no_write: assert property (@(posedge clk) disable iff (rst)
                chr_we_n);
        end
    endgenerate

endmodule

// File: tb/bank_mapper_tb.sv
`timescale 1ns/1ps
module bank_mapper_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        cpu_m2 = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic        ppu_rd_n = 1'b1;
    logic        ppu_wr_n = 1'b1;
    logic        scan_tick = 1'b0;

    logic [17:0] prg_addr, prg_addr_r;
    logic [17:0] chr_addr, chr_addr_r;
    logic        prg_rom_ce_n, wram_ce_n, xram_ce_n, chr_ce_n, chr_we_n, ciram_a10, irq_n;
    logic        prg_rom_ce_n_r, wram_ce_n_r, xram_ce_n_r, chr_ce_n_r, chr_we_n_r, ciram_a10_r, irq_n_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_mapper u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .ppu_addr(ppu_addr),
        .ppu_rd_n(ppu_rd_n), .ppu_wr_n(ppu_wr_n), .scan_tick(scan_tick),
        .prg_addr(prg_addr), .prg_rom_ce_n(prg_rom_ce_n), .wram_ce_n(wram_ce_n),
        .xram_ce_n(xram_ce_n), .chr_addr(chr_addr), .chr_ce_n(chr_ce_n),
        .chr_we_n(chr_we_n), .ciram_a10(ciram_a10), .irq_n(irq_n)
    );

    bank_mapper #(.CHR_RAM(1'b1)) u_ram (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .ppu_addr(ppu_addr),
        .ppu_rd_n(ppu_rd_n), .ppu_wr_n(ppu_wr_n), .scan_tick(scan_tick),
        .prg_addr(prg_addr_r), .prg_rom_ce_n(prg_rom_ce_n_r), .wram_ce_n(wram_ce_n_r),
        .xram_ce_n(xram_ce_n_r), .chr_addr(chr_addr_r), .chr_ce_n(chr_ce_n_r),
        .chr_we_n(chr_we_n_r), .ciram_a10(ciram_a10_r), .irq_n(irq_n_r)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; cpu_m2 = 1'b1;
        @(posedge clk); #2;
        cpu_m2 = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'h0000;
        #1;
    endtask

    task automatic line_tick();
        @(posedge clk); #2; scan_tick = 1'b1;
        @(posedge clk); #2; scan_tick = 1'b0;
        #1;
    endtask

    task automatic write_with_tick(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; cpu_m2 = 1'b1; scan_tick = 1'b1;
        @(posedge clk); #2;
        cpu_m2 = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'h0000; scan_tick = 1'b0;
        #1;
    endtask

    function automatic logic [7:0] cval(input int n, input bit inv);
        logic [7:0] v;
        v = 8'((n * 37 + 5) & 255);
        return inv ? ~v : v;
    endfunction

    function automatic logic [4:0] pval(input int s, input bit inv);
        logic [4:0] v;
        v = 5'((s * 7 + 3) & 31);
        return inv ? ~v : v;
    endfunction

    task automatic check_chr(input bit inv, input string req);
        int offs [4] = '{0, 1, 'h2AA, 'h3FF};
        for (int n = 0; n < 8; n++) begin
            for (int k = 0; k < 4; k++) begin
                ppu_addr = 14'(n * 1024 + offs[k]);
                #1;
                chk(req, 32'(chr_addr), 32'({cval(n, inv), 10'(offs[k])}));
            end
        end
    endtask

    task automatic check_prg(input bit inv, input string req);
        int offs [3] = '{0, 'h0ABC, 'h1FFF};
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                logic [4:0] b;
                cpu_addr = 16'(16'h8000 + s * 16'h2000 + offs[k]);
                b = (s < 3) ? pval(s, inv) : 5'h1F;
                #1;
                chk((s < 3) ? req : "R5", 32'(prg_addr), 32'({b, 13'(offs[k])}));
            end
        end
        cpu_addr = 16'h0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #1;

        // R2 reset state
        ppu_addr = 14'h1C05; #1;
        chk("R2 chr bank zero", 32'(chr_addr), 32'h005);
        cpu_addr = 16'h8123; #1;
        chk("R2 prg bank zero", 32'(prg_addr), 32'h0123);
        ppu_addr = 14'h2400; #1;
        chk("R2 vertical a10", 32'(ciram_a10), 32'd1);
        ppu_addr = 14'h2800; #1;
        chk("R2 vertical a11", 32'(ciram_a10), 32'd0);
        chk("R2 irq idle", 32'(irq_n), 32'd1);
        cpu_addr = 16'h0000;

        // R3 / R4 / R5 pattern one
        for (int n = 0; n < 8; n++) cpu_write(16'(16'h40C0 + n), cval(n, 1'b0));
        for (int s = 0; s < 3; s++) cpu_write(16'(16'h40C8 + s), 8'(pval(s, 1'b0)));
        check_chr(1'b0, "R3 pattern A");
        check_prg(1'b0, "R4 pattern A");
        // R8 flat RAM build ignores bank registers
        for (int n = 0; n < 8; n++) begin
            ppu_addr = 14'(n * 1024 + 'h155); #1;
            chk("R8 flat chr addr", 32'(chr_addr_r), 32'(n * 1024 + 'h155));
        end

        // R3 / R4 pattern two
        for (int n = 0; n < 8; n++) cpu_write(16'(16'h40C0 + n), cval(n, 1'b1));
        for (int s = 0; s < 3; s++) cpu_write(16'(16'h40C8 + s), 8'(pval(s, 1'b1)));
        check_chr(1'b1, "R3 pattern B");
        check_prg(1'b1, "R4 pattern B");

        // R1 ignored writes
        @(posedge clk); #2;
        cpu_addr = 16'h40C0; cpu_data = 8'h00; cpu_rw = 1'b0; cpu_m2 = 1'b0;
        @(posedge clk); #2; cpu_rw = 1'b1; cpu_m2 = 1'b1;
        @(posedge clk); #2; cpu_m2 = 1'b0; cpu_addr = 16'h0000;
        cpu_write(16'h40CF, 8'h00);
        cpu_write(16'h50C0, 8'h00);
        cpu_write(16'h40D8, 8'h00);
        check_chr(1'b1, "R1 no latch");
        check_prg(1'b1, "R1 no latch");
        ppu_addr = 14'h2400; #1;
        chk("R1 mirror kept", 32'(ciram_a10), 32'd1);

        // R6 mirroring sweep
        for (int m = 0; m < 4; m++) begin
            cpu_write(16'h40CB, 8'(m));
            for (int k = 0; k < 4; k++) begin
                logic e;
                ppu_addr = 14'(14'h2000 + k * 14'h400 + 14'h3A);
                e = (m == 0) ? 1'b0 : (m == 1) ? 1'b1 : (m == 2) ? k[1] : k[0];
                #1;
                chk("R6 mirroring", 32'(ciram_a10), 32'(e));
            end
        end

        // R7 chip-enable sweep
        for (int rw = 0; rw < 2; rw++) begin
            for (int a = 0; a < 65536; a += 128) begin
                logic er, ew, ex;
                cpu_rw = rw[0]; cpu_addr = 16'(a);
                er = !(rw[0] && a >= 'h8000);
                ew = !(a >= 'h6000 && a < 'h8000);
                ex = !(a >= 'h5000 && a < 'h6000);
                #1;
                chk("R7 selects", 32'({prg_rom_ce_n, wram_ce_n, xram_ce_n}), 32'({er, ew, ex}));
            end
        end
        cpu_rw = 1'b1; cpu_addr = 16'h0000;

        // R8 write enables
        ppu_addr = 14'h0123; ppu_wr_n = 1'b0; #1;
        chk("R8 ram write", 32'(chr_we_n_r), 32'd0);
        chk("R8 rom no write", 32'(chr_we_n), 32'd1);
        chk("R8 chr select", 32'(chr_ce_n), 32'd0);
        ppu_addr = 14'h2123; #1;
        chk("R8 ram write above", 32'(chr_we_n_r), 32'd1);
        ppu_wr_n = 1'b1; #1;

        // R10 disabled: match does not raise
        cpu_write(16'h40CE, 8'd1);
        line_tick();
        chk("R10 disabled no irq", 32'(irq_n), 32'd1);

        // R10 enabled match
        cpu_write(16'h40CE, 8'd5);
        cpu_write(16'h40CD, 8'h00);
        for (int i = 0; i < 4; i++) line_tick();
        chk("R10 before target", 32'(irq_n), 32'd1);
        line_tick();
        chk("R10 at target", 32'(irq_n), 32'd0);
        line_tick();
        chk("R10 sticky", 32'(irq_n), 32'd0);
        cpu_write(16'h40CC, 8'h00);
        chk("R11 ack", 32'(irq_n), 32'd1);

        // R11 ack colliding with a match
        cpu_write(16'h40CE, 8'd3);
        cpu_write(16'h40CD, 8'h00);
        line_tick();
        line_tick();
        write_with_tick(16'h40CC, 8'h00);
        chk("R11 ack beats match", 32'(irq_n), 32'd1);
        cpu_write(16'h40CD, 8'h00);
        for (int i = 0; i < 255; i++) line_tick();
        chk("R11 count kept, before wrap", 32'(irq_n), 32'd1);
        line_tick();
        chk("R11 count kept, after wrap", 32'(irq_n), 32'd0);
        cpu_write(16'h40CC, 8'h00);

        // R9 load colliding with a tick
        write_with_tick(16'h40CE, 8'd2);
        cpu_write(16'h40CD, 8'h00);
        line_tick();
        chk("R9 tick dropped on load", 32'(irq_n), 32'd1);
        line_tick();
        chk("R9 count from zero", 32'(irq_n), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule